// File: doc/BRIEF.md
# Zero-Run Skipping Error Signature Engine

This block compacts the difference between two response streams into a signature. It accepts a pair of `PART_W`-bit partitions per handshake: the response observed from the circuit under test and the fault-free response. It stores their XOR, the error partition, in a circular queue. The signature register is an internal-XOR divider with polynomial `POLY` and a zero seed. Its result equals the XOR of the faulty and fault-free signatures. A zero result means the two streams compacted to the same value.

Error streams tend to be mostly zero, so the engine does not shift every partition through the register. A scanner walks the leading `CHECK_LEN` partitions at the queue head backward, starting from the far end. It stops at the first nonzero partition, which is the last nonzero one in that window. If the window is all zero, the register takes a fixed precomputed jump of `CHECK_LEN*PART_W` autonomous steps in one cycle. Otherwise the partitions from the head up to the hit are shifted in one per cycle. The zero partitions that follow the hit are remembered, so the next scan stops early.

When the stream marker arrives, a trailing group shorter than the check window is shifted in partition by partition. The signature is then presented for one cycle, and the register clears for the next stream. Setting `CHECK_LEN` below `WIN` gives a short-pivot variant: only the leading partitions are tested, and the jump distance is reduced to match.

Top module: `err_sig_engine`

## Requirements
- R1: Each stored error partition is `inObs ^ inExp`. The signature equals a bit-serial internal-XOR register that starts at zero and takes the error stream most significant bit first. For each bit, with `fb = state[SIG_W-1] ^ bit`, the update is `state = (state << 1) ^ (fb ? POLY : 0)`.
- R2: When the observed and expected streams are identical, the emitted signature is zero.
- R3: An all-zero check window of `CHECK_LEN` partitions is retired in one cycle. The register advances by exactly `CHECK_LEN*PART_W` zero-input steps, so zero runs after nonzero history still give the bit-serial result.
- R4: When a window holds a nonzero partition, the partitions from the head through the last nonzero one are shifted in one per cycle. The zeros after it are counted as already checked, and the result is unchanged.
- R5: With `CHECK_LEN` smaller than `WIN`, only that many leading partitions are tested, the jump covers `CHECK_LEN*PART_W` steps, and the signature still obeys R1.
- R6: After the partition flagged with `inLast` is accepted, `inReady` stays low until the signature has been presented.
- R7: A new group of `WIN` partitions is admitted only when the queue of `2*WIN` entries has room for all of it. The queue never overflows, and no partition is lost on a continuous stream.
- R8: A trailing group shorter than `CHECK_LEN` at the end marker is shifted in with ordinary steps. Streams of any length, including lengths below one window, give the R1 result.
- R9: `sigValid` is high for exactly one cycle per stream. The register then returns to zero, so the next stream is independent of the previous one.
- R10: After reset, `inReady` is high and `sigValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Partition pair present |
| inReady | output | 1 | Engine accepts the pair this cycle |
| inObs | input | PART_W | Observed response partition |
| inExp | input | PART_W | Fault-free response partition |
| inLast | input | 1 | Marks the final partition of a stream |
| sigValid | output | 1 | Signature presented (one cycle) |
| sigOut | output | SIG_W | Error signature |

## Verification
The assertions assume the producer holds a pair stable while `inReady` is low. They also assume every stream ends with exactly one `inLast` partition and that nothing is offered until the signature has been presented. The stimulus drives each pair at the falling edge and holds it until a falling-edge sample sees `inReady` high. It raises `inLast` only on the final element and waits for `sigValid` before starting another stream. Error streams are generated with a chosen density of nonzero partitions, so long zero runs, dense runs, single hits at window edges and sub-window lengths all occur. Both the full-window and short-pivot variants are compared with a bit-serial model.

// File: rtl/err_sig_pkg.sv
package err_sig_pkg;

  typedef struct packed {
    logic push;
    logic step;
    logic jump;
    logic clear;
  } strobe_t;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_SCAN   = 3'd1,
    S_RUN    = 3'd2,
    S_FLUSH  = 3'd3,
    S_FINISH = 3'd4
  } ctrl_state_t;

endpackage

// File: rtl/err_sig_datapath.sv
module err_sig_datapath #(
  parameter int SIG_W = 32,
  parameter int PART_W = 8,
  parameter int WIN = 4,
  parameter int CHECK_LEN = 4,
  parameter logic [SIG_W-1:0] POLY = 32'h04C11DB7,
  localparam int QD = 2 * WIN,
  localparam int PW = $clog2(QD),
  localparam int CW = $clog2(QD + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  err_sig_pkg::strobe_t   stb,
  input  logic [PART_W-1:0]      inObs,
  input  logic [PART_W-1:0]      inExp,
  input  logic [PW-1:0]          scanOff,
  output logic                   peekZero,
  output logic [CW-1:0]          count,
  output logic [SIG_W-1:0]       sig
);

  localparam int JUMP_STEPS = CHECK_LEN * PART_W;
  localparam logic [PW:0] QD_X = (PW + 1)'(QD);
  localparam logic [PW:0] L_X = (PW + 1)'(CHECK_LEN);
  localparam logic [CW-1:0] L_C = CW'(CHECK_LEN);
  localparam logic [CW-1:0] QD_C = CW'(QD);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [PART_W-1:0] qMem [QD];
  logic [PW-1:0] headPtr, wrPtr;
  logic [SIG_W-1:0] stateQ;

  function automatic logic [PW-1:0] wrapIdx(input logic [PW:0] v);
    logic [PW:0] t;
    t = (v >= QD_X) ? v - QD_X : v;
    return t[PW-1:0];
  endfunction

  function automatic logic [SIG_W-1:0] stepPart(input logic [SIG_W-1:0] s,
                                                input logic [PART_W-1:0] d);
    logic [SIG_W-1:0] r;
    r = s;
    for (int i = PART_W - 1; i >= 0; i--) begin
      if (r[SIG_W-1] ^ d[i]) r = {r[SIG_W-2:0], 1'b0} ^ POLY;
      else                   r = {r[SIG_W-2:0], 1'b0};
    end
    return r;
  endfunction

  function automatic logic [SIG_W-1:0] advance(input logic [SIG_W-1:0] s);
    logic [SIG_W-1:0] r;
    r = s;
    for (int i = 0; i < JUMP_STEPS; i++) begin
      if (r[SIG_W-1]) r = {r[SIG_W-2:0], 1'b0} ^ POLY;
      else            r = {r[SIG_W-2:0], 1'b0};
    end
    return r;
  endfunction

  logic [PART_W-1:0] headData, peekData;
  logic [SIG_W-1:0] stepNext, jumpNext;
  logic [CW-1:0] popAmt, pushAmt;

  always_comb begin
    headData = qMem[headPtr];
    peekData = qMem[wrapIdx({1'b0, headPtr} + {1'b0, scanOff})];
    peekZero = (peekData == '0);
    stepNext = stepPart(stateQ, headData);
    jumpNext = advance(stateQ);
    popAmt   = stb.jump ? L_C : (stb.step ? ONE_C : '0);
    pushAmt  = stb.push ? ONE_C : '0;
  end

  always_ff @(posedge clk) begin
    if (stb.push) qMem[wrPtr] <= inObs ^ inExp;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      wrPtr   <= '0;
      count   <= '0;
      stateQ  <= '0;
    end else begin
      if (stb.push) wrPtr <= wrapIdx({1'b0, wrPtr} + 1'b1);
      if (stb.jump)      headPtr <= wrapIdx({1'b0, headPtr} + L_X);
      else if (stb.step) headPtr <= wrapIdx({1'b0, headPtr} + 1'b1);
      count <= count + pushAmt - popAmt;
      if (stb.clear)     stateQ <= '0;
      else if (stb.jump) stateQ <= jumpNext;
      else if (stb.step) stateQ <= stepNext;
    end
  end

  assign sig = stateQ;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.push |-> (count < QD_C)); // R7
  AST_STEP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    stb.step |-> (count != '0)); // R4
  AST_JUMP_HAS_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    stb.jump |-> (count >= L_C)); // R3
  AST_SIG_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    stb.clear |=> (sig == '0)); // R9

endmodule

// File: rtl/err_sig_control.sv
module err_sig_control #(
  parameter int WIN = 4,
  parameter int CHECK_LEN = 4,
  localparam int QD = 2 * WIN,
  localparam int PW = $clog2(QD),
  localparam int CW = $clog2(QD + 1),
  localparam int FW = $clog2(WIN)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic                  inLast,
  input  logic [CW-1:0]         count,
  input  logic                  peekZero,
  output err_sig_pkg::strobe_t  stb,
  output logic [PW-1:0]         scanOff,
  output logic                  inReady,
  output logic                  sigValid
);
  import err_sig_pkg::*;

  localparam logic [CW-1:0] L_C = CW'(CHECK_LEN);
  localparam logic [CW-1:0] QD_C = CW'(QD);
  localparam logic [CW-1:0] WIN_C = CW'(WIN);
  localparam logic [CW-1:0] ONE_C = CW'(1);
  localparam logic [PW-1:0] LM1_P = PW'(CHECK_LEN - 1);
  localparam logic [PW-1:0] ONE_P = PW'(1);
  localparam logic [FW-1:0] FILL_MAX = FW'(WIN - 1);

  ctrl_state_t stateQ;
  logic [FW-1:0] fillCnt;
  logic lastSeen;
  logic [PW-1:0] knownZero, scanIdx, runLeft;
  logic [CW-1:0] freeSlots;
  logic accept;

  always_comb begin
    freeSlots = QD_C - count;
    inReady   = !lastSeen && ((fillCnt != '0) || (freeSlots >= WIN_C));
    accept    = inValid && inReady;
    scanOff   = scanIdx;
    sigValid  = (stateQ == S_FINISH);
    stb.push  = accept;
    stb.step  = (stateQ == S_RUN) || (stateQ == S_FLUSH);
    stb.jump  = (stateQ == S_SCAN) && peekZero && (scanIdx == knownZero);
    stb.clear = (stateQ == S_FINISH);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillCnt  <= '0;
      lastSeen <= 1'b0;
    end else begin
      if (accept) begin
        if (inLast || fillCnt == FILL_MAX) fillCnt <= '0;
        else fillCnt <= fillCnt + 1'b1;
        if (inLast) lastSeen <= 1'b1;
      end else if (stateQ == S_FINISH) begin
        lastSeen <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= S_IDLE;
      knownZero <= '0;
      scanIdx   <= '0;
      runLeft   <= '0;
    end else begin
      case (stateQ)
        S_IDLE: begin
          if (count >= L_C) begin
            scanIdx <= LM1_P;
            stateQ  <= S_SCAN;
          end else if (lastSeen) begin
            stateQ <= (count != '0) ? S_FLUSH : S_FINISH;
          end
        end
        S_SCAN: begin
          if (!peekZero) begin
            runLeft   <= scanIdx + 1'b1;
            knownZero <= LM1_P - scanIdx;
            stateQ    <= S_RUN;
          end else if (scanIdx == knownZero) begin
            knownZero <= '0;
            stateQ    <= S_IDLE;
          end else begin
            scanIdx <= scanIdx - 1'b1;
          end
        end
        S_RUN: begin
          runLeft <= runLeft - 1'b1;
          if (runLeft == ONE_P) stateQ <= S_IDLE;
        end
        S_FLUSH: begin
          if (count == ONE_C) stateQ <= S_FINISH;
        end
        S_FINISH: begin
          knownZero <= '0;
          stateQ    <= S_IDLE;
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end

  AST_READY_LOW_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady && inLast) |=> !inReady); // R6
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sigValid |=> !sigValid); // R9
  AST_ONE_STATE_ACTION: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.step, stb.jump, stb.clear})); // R3
  AST_KNOWN_ZERO_IN_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_SCAN) |-> (knownZero <= scanIdx)); // R4

endmodule

// File: rtl/err_sig_engine.sv
module err_sig_engine #(
  parameter int SIG_W = 32,
  parameter int PART_W = 8,
  parameter int WIN = 4,
  parameter int CHECK_LEN = WIN,
  parameter logic [SIG_W-1:0] POLY = 32'h04C11DB7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [PART_W-1:0] inObs,
  input  logic [PART_W-1:0] inExp,
  input  logic              inLast,
  output logic              sigValid,
  output logic [SIG_W-1:0]  sigOut
);

  localparam int QD = 2 * WIN;
  localparam int PW = $clog2(QD);
  localparam int CW = $clog2(QD + 1);

  err_sig_pkg::strobe_t stb;
  logic [PW-1:0] scanOff;
  logic peekZero;
  logic [CW-1:0] count;

  err_sig_control #(.WIN(WIN), .CHECK_LEN(CHECK_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .count(count), .peekZero(peekZero), .stb(stb), .scanOff(scanOff),
    .inReady(inReady), .sigValid(sigValid)
  );

  err_sig_datapath #(.SIG_W(SIG_W), .PART_W(PART_W), .WIN(WIN),
                     .CHECK_LEN(CHECK_LEN), .POLY(POLY)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inObs(inObs), .inExp(inExp),
    .scanOff(scanOff), .peekZero(peekZero), .count(count), .sig(sigOut)
  );

endmodule

// File: tb/err_sig_engine_tb.sv
module err_sig_engine_tb;

  localparam int SIG_W = 32;
  localparam int PART_W = 8;
  localparam logic [SIG_W-1:0] POLY = 32'h04C11DB7;

  // stimulus vectors: length[31:24], error density percent[23:16], seed[15:0]
  localparam int NVEC = 8;
  localparam logic [31:0] VEC [NVEC] = '{
    {8'd16, 8'd5,   16'h1A2B},
    {8'd33, 8'd3,   16'h0F0F},
    {8'd64, 8'd10,  16'h7331},
    {8'd24, 8'd50,  16'h2222},
    {8'd9,  8'd100, 16'h5A5A},
    {8'd61, 8'd2,   16'h0101},
    {8'd7,  8'd20,  16'h3C3C},
    {8'd48, 8'd8,   16'h4D4D}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic validA = 1'b0, validB = 1'b0;
  logic rdyA, rdyB, svA, svB;
  logic [PART_W-1:0] obsBus = '0, expBus = '0;
  logic lastBus = 1'b0;
  logic [SIG_W-1:0] sigA, sigB;

  logic [PART_W-1:0] obsArr [64];
  logic [PART_W-1:0] errArr [64];
  logic [31:0] lcg;
  int nRun = 0, nFail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  err_sig_engine u_dut (
    .clk(clk), .rstN(rstN), .inValid(validA), .inReady(rdyA),
    .inObs(obsBus), .inExp(expBus), .inLast(lastBus),
    .sigValid(svA), .sigOut(sigA)
  );

  err_sig_engine #(.CHECK_LEN(2)) u_dut_pivot (
    .clk(clk), .rstN(rstN), .inValid(validB), .inReady(rdyB),
    .inObs(obsBus), .inExp(expBus), .inLast(lastBus),
    .sigValid(svB), .sigOut(sigB)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRand();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg;
  endfunction

  function automatic logic [SIG_W-1:0] refSig(input int len);
    logic [SIG_W-1:0] s;
    logic fb;
    s = '0;
    for (int p = 0; p < len; p++) begin
      for (int b = PART_W - 1; b >= 0; b--) begin
        fb = s[SIG_W-1] ^ errArr[p][b];
        s = {s[SIG_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
    end
    return s;
  endfunction

  task automatic fillRandom(input int len, input int dens, input logic [15:0] seed);
    logic [31:0] r;
    lcg = {16'hC0DE, seed};
    for (int p = 0; p < 64; p++) begin
      r = nextRand();
      obsArr[p] = r[23:16];
      r = nextRand();
      if (p < len && int'(r[30:16] % 100) < dens) begin
        errArr[p] = r[7:0];
        if (errArr[p] == '0) errArr[p] = 8'h01;
      end else begin
        errArr[p] = '0;
      end
    end
  endtask

  task automatic fillObs(input logic [15:0] seed);
    logic [31:0] r;
    lcg = {16'hBEEF, seed};
    for (int p = 0; p < 64; p++) begin
      r = nextRand();
      obsArr[p] = r[23:16];
      errArr[p] = '0;
    end
  endtask

  task automatic runStream(input int sel, input int len, input string tag);
    int cyc;
    logic [SIG_W-1:0] got;
    logic [SIG_W-1:0] want;
    for (int p = 0; p < len; p++) begin
      @(negedge clk);
      obsBus = obsArr[p];
      expBus = obsArr[p] ^ errArr[p];
      lastBus = (p == len - 1);
      if (sel == 0) validA = 1'b1; else validB = 1'b1;
      cyc = 0;
      while (!((sel == 0) ? rdyA : rdyB) && cyc < 1000) begin
        @(negedge clk);
        cyc++;
      end
    end
    @(negedge clk);
    validA = 1'b0;
    validB = 1'b0;
    lastBus = 1'b0;
    // R6: ready must be low right after the final partition is taken
    check(!((sel == 0) ? rdyA : rdyB), "R6 ready after last", 32'((sel == 0) ? rdyA : rdyB), 32'd0);
    cyc = 0;
    while (!((sel == 0) ? svA : svB) && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    got = (sel == 0) ? sigA : sigB;
    want = refSig(len);
    check(((sel == 0) ? svA : svB) && got == want, tag, got, want);
    @(negedge clk);
    // R9: valid lasts a single cycle
    check(!((sel == 0) ? svA : svB), "R9 valid pulse", 32'((sel == 0) ? svA : svB), 32'd0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nRun++;
        nFail++;
        $display("FAIL watchdog actual=%0d expected=<150000", cycles);
        $display("[TB] %0d tests run, %0d failed", nRun, nFail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10: reset state
    check(rdyA && rdyB, "R10 ready after reset", {30'd0, rdyA, rdyB}, 32'd3);
    check(!svA && !svB, "R10 valid after reset", {30'd0, svA, svB}, 32'd0);

    // table walk: R1 R7 on full window, R5 on pivot variant
    for (int v = 0; v < NVEC; v++) begin
      fillRandom(int'(VEC[v][31:24]), int'(VEC[v][23:16]), VEC[v][15:0]);
      runStream(0, int'(VEC[v][31:24]), "R1 R7 table vector");
      runStream(1, int'(VEC[v][31:24]), "R5 pivot table vector");
    end

    // R2: identical streams give zero
    fillObs(16'h0042);
    runStream(0, 20, "R2 equal streams");
    check(sigA == '0, "R2 zero signature", sigA, 32'd0);
    runStream(1, 20, "R2 equal streams pivot");

    // R3: nonzero history followed by whole zero windows
    fillObs(16'h0077);
    errArr[0] = 8'h80;
    runStream(0, 12, "R3 jump after history");
    runStream(1, 12, "R3 R5 jump after history pivot");

    // R4: hits at the far end of the window and at the start of the next
    fillObs(16'h0099);
    errArr[1] = 8'h01;
    errArr[3] = 8'h5A;
    errArr[4] = 8'hFF;
    runStream(0, 13, "R4 hit at window edges");
    runStream(1, 13, "R4 R5 hit at window edges pivot");

    // R4: one hit at window start, rest of the window proven zero
    fillObs(16'h00AA);
    errArr[4] = 8'h10;
    errArr[11] = 8'h03;
    runStream(0, 16, "R4 proven zero tail");

    // R8: streams shorter than a window and ragged ends
    fillRandom(3, 100, 16'h0303);
    runStream(0, 3, "R8 short stream");
    runStream(1, 3, "R8 short stream pivot");
    fillRandom(6, 60, 16'h0606);
    runStream(0, 6, "R8 ragged end");
    fillRandom(1, 100, 16'h0001);
    runStream(0, 1, "R8 single partition");

    // R9: back-to-back streams are independent
    fillRandom(10, 30, 16'h0A0A);
    runStream(0, 10, "R9 first stream");
    runStream(0, 10, "R9 repeat stream");

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule